// File: doc/BRIEF.md
# Asynchronous Byte-Wide ROM Read Sequencer

This block sits on the host side of a parallel, clockless read-only memory with two active-low strobes. One strobe selects the device and the other lets it drive the data bus. The system side offers a 20-bit byte address on a valid/ready request channel. For each accepted request the block drives the address and lowers the select strobe on the same clock edge. It lowers the output strobe part-way through the access, samples the returned byte once both strobes have been low long enough, and hands the byte back with a one-cycle valid pulse. It then raises both strobes together and waits out the bus-float time before it accepts another request.

All three delays are counted in clock cycles and set by parameters. `ACC_CYC` is the address/select-to-data time. `OE_CYC` is the output-strobe-to-data time. `FLT_CYC` is the turnaround for the data bus to float. The defaults of 24, 12 and 10 cycles are 120 ns, 60 ns and 50 ns at a 5 ns clock. Request back-pressure: `req_ready` is high only while the block is idle, so a requester must hold `req_valid` and `req_addr` steady until a cycle in which both `req_valid` and `req_ready` are high. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse and `rsp_data` keeps the last byte until the next pulse.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it: `mem_ce_n`=1, `mem_oe_n`=1, `rsp_valid`=0, `req_ready`=1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. On that edge `mem_addr` takes `req_addr`, and it stays unchanged until the next request is taken. `req_ready` is 0 from the accepting edge until the turnaround ends.
- R3: `mem_ce_n` falls on the same edge that takes the request.
- R4: `mem_oe_n` falls exactly `ACC_CYC-OE_CYC` cycles after `mem_ce_n` fell. It is never 0 while `mem_ce_n` is 1.
- R5: `ACC_CYC` cycles after `mem_ce_n` fell, the value on `mem_dq_in` is registered into `rsp_data`. `rsp_valid` is 1 for exactly the following cycle.
- R6: `mem_ce_n` and `mem_oe_n` both rise on the same edge that samples the byte.
- R7: `req_ready` returns to 1 exactly `FLT_CYC` cycles after the strobes rose.
- R8: Whenever no access is in progress (`req_ready`=1), `mem_ce_n`=1 and `mem_oe_n`=1, which keeps the device in standby.
- R9: `rsp_data` holds its value between `rsp_valid` pulses.
- R10: Changes on `req_addr` while `req_valid` is 0 or the block is busy have no effect on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 20 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` is new |
| rsp_data | output | 8 | Last byte read |
| mem_addr | output | 20 | Address to the memory |
| mem_ce_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Output drive enable, active low |
| mem_dq_in | input | 8 | Data bus from the memory |

## Verification
The assertions assume the requester keeps `req_valid` and `req_addr` steady until the request is taken, and that the memory drives `mem_dq_in` only from the strobes and address that this block presents. The stimulus holds each request until the reference model sees it accepted, and only changes the address after that. The bench memory model returns the correct byte only after the select strobe, the output strobe and the address have each been held for their full delay; otherwise it returns the inverted byte. As a result, a capture even one cycle early shows up as a data miscompare.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/eprom_rd_timer.sv
// Elapsed-cycle counter: loads 1 on restart, otherwise counts up and saturates.
module eprom_rd_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_o <= '0;
    else if (restart)
      count_o <= CNT_W'(1);
    else if (count_o != CNT_MAX)
      count_o <= count_o + CNT_W'(1);
  end
endmodule

// File: rtl/eprom_rd_seq.sv
// Strobe sequencer: idle -> access (select, then output drive) -> float turnaround.
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int ACC_CYC = 24,
  parameter int OE_CYC  = 12,
  parameter int FLT_CYC = 10,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] count_i,
  output logic             req_ready,
  output logic             accept_o,
  output logic             restart_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             oe_n_o
);
  localparam logic [CNT_W-1:0] T_OE_ON = CNT_W'(ACC_CYC - OE_CYC);
  localparam logic [CNT_W-1:0] T_DATA  = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] T_FLOAT = CNT_W'(FLT_CYC);

  rd_state_e st_q;

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    accept_o  = req_ready && req_valid;
    capture_o = (st_q == ST_ACCESS) && (count_i == T_DATA);
    restart_o = accept_o || capture_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ce_n_o <= 1'b1;
      oe_n_o <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept_o) begin
            st_q   <= ST_ACCESS;
            ce_n_o <= 1'b0;
          end
        end
        ST_ACCESS: begin
          if (count_i == T_OE_ON)
            oe_n_o <= 1'b0;
          if (capture_o) begin
            ce_n_o <= 1'b1;
            oe_n_o <= 1'b1;
            st_q   <= ST_FLOAT;
          end
        end
        ST_FLOAT: begin
          if (count_i == T_FLOAT)
            st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eprom_rd_capture.sv
// Registers the returned byte and produces the single-cycle valid pulse.
module eprom_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture_i;
      if (capture_i)
        rsp_data <= dq_i;
    end
  end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 24,
  parameter int OE_CYC  = 12,
  parameter int FLT_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int LONGEST = (ACC_CYC > FLT_CYC) ? ACC_CYC : FLT_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 2);

  logic [CNT_W-1:0] count;
  logic             accept, restart, capture;

  eprom_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .count_o (count)
  );

  eprom_rd_seq #(
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC),
    .FLT_CYC (FLT_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .count_i   (count),
    .req_ready (req_ready),
    .accept_o  (accept),
    .restart_o (restart),
    .capture_o (capture),
    .ce_n_o    (mem_ce_n),
    .oe_n_o    (mem_oe_n)
  );

  eprom_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .dq_i      (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // Address is launched with the select strobe and held until the next accept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mem_addr <= '0;
    else if (accept)
      mem_addr <= req_addr;
  end
endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk #(
  parameter int ADDR_W  = 20,
  parameter int ACC_CYC = 24,
  parameter int OE_CYC  = 12,
  parameter int FLT_CYC = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n
);
  localparam int LONGEST = (ACC_CYC > FLT_CYC) ? ACC_CYC : FLT_CYC;
  localparam int CW      = $clog2(LONGEST + 3);
  localparam logic [CW-1:0] LOW_SAT  = CW'(ACC_CYC + 1);
  localparam logic [CW-1:0] HIGH_SAT = CW'(FLT_CYC + 1);

  logic [CW-1:0] ce_low_cnt, ce_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_low_cnt  <= '0;
      ce_high_cnt <= '0;
    end else begin
      if (mem_ce_n)
        ce_low_cnt <= '0;
      else if (ce_low_cnt != LOW_SAT)
        ce_low_cnt <= ce_low_cnt + CW'(1);
      if (!mem_ce_n)
        ce_high_cnt <= '0;
      else if (ce_high_cnt != HIGH_SAT)
        ce_high_cnt <= ce_high_cnt + CW'(1);
    end
  end

  assert_accept_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_ce_n && mem_addr == $past(req_addr)));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_oe_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  assert_oe_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (ce_low_cnt == CW'(ACC_CYC - OE_CYC)));

  assert_access_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (ce_low_cnt == CW'(ACC_CYC)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_joint_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($rose(mem_ce_n) && $rose(mem_oe_n)));

  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (ce_high_cnt == CW'(FLT_CYC)));

  assert_idle_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n));
endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
  .ADDR_W  (ADDR_W),
  .ACC_CYC (ACC_CYC),
  .OE_CYC  (OE_CYC),
  .FLT_CYC (FLT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;
  localparam int ACC = 24;
  localparam int OE  = 12;
  localparam int FLT = 10;
  localparam int AW  = 20;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] mem_dq_in = '0;
  logic          req_ready, rsp_valid, mem_ce_n, mem_oe_n;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;

  eprom_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .OE_CYC(OE), .FLT_CYC(FLT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq_in(mem_dq_in)
  );

  always #2.5 clk = ~clk;

  // Reference model state: edge count, edge of last accept, its address, last byte.
  int            cyc = 0;
  int            acc_at = -1000;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] hold_byte = '0;
  int            vectors = 0;
  int            fails = 0;
  bit            done = 1'b0;
  // Memory model hold counters.
  int            ce_cnt = 0, oe_cnt = 0, ad_cnt = 0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] ad);
    return ad[7:0] ^ ad[15:8] ^ {ad[19:16], ad[19:16]} ^ 8'hA5;
  endfunction

  function automatic bit exp_ready(input int c);
    return !(c >= acc_at && c <= acc_at + ACC + FLT - 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst_n && req_valid && exp_ready(cyc)) begin
      acc_at   = cyc + 1;
      acc_addr = req_addr;
    end
    cyc = cyc + 1;
    if (cyc == acc_at + ACC) hold_byte = mem_byte(acc_addr);
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_ce, e_oe, e_rv, e_rdy;
      e_ce  = !(cyc >= acc_at && cyc <= acc_at + ACC - 1);
      e_oe  = !(cyc >= acc_at + ACC - OE && cyc <= acc_at + ACC - 1);
      e_rv  = (cyc == acc_at + ACC);
      e_rdy = exp_ready(cyc);
      check(mem_ce_n == e_ce, "R3/R6/R8", "mem_ce_n", int'(mem_ce_n), int'(e_ce));
      check(mem_oe_n == e_oe, "R4/R6", "mem_oe_n", int'(mem_oe_n), int'(e_oe));
      check(rsp_valid == e_rv, "R5", "rsp_valid", int'(rsp_valid), int'(e_rv));
      check(rsp_data == hold_byte, "R5/R9", "rsp_data", int'(rsp_data), int'(hold_byte));
      check(req_ready == e_rdy, "R2/R7", "req_ready", int'(req_ready), int'(e_rdy));
      check(mem_addr == acc_addr, "R2/R10", "mem_addr", int'(mem_addr), int'(acc_addr));
    end
    // Memory: correct byte only once every hold time has been met.
    ce_cnt    = mem_ce_n ? 0 : ce_cnt + 1;
    oe_cnt    = mem_oe_n ? 0 : oe_cnt + 1;
    ad_cnt    = (mem_addr == prev_addr) ? ad_cnt + 1 : 1;
    prev_addr = mem_addr;
    mem_dq_in = (ce_cnt >= ACC && oe_cnt >= OE && ad_cnt >= ACC) ?
                mem_byte(mem_addr) : ~mem_byte(mem_addr);
  end

  task automatic issue(input logic [AW-1:0] ad, input int gap);
    req_valid = 1'b1;
    req_addr  = ad;
    do @(negedge clk); while (acc_at != cyc);
    req_valid = 1'b0;
    req_addr  = ~ad ^ 20'h0F0F0;   // R10: wiggle while busy
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(mem_ce_n == 1'b1, "R1", "mem_ce_n", int'(mem_ce_n), 1);
    check(mem_oe_n == 1'b1, "R1", "mem_oe_n", int'(mem_oe_n), 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue(20'h00000, 5);
    issue(20'hFFFFF, 0);          // back-to-back: waits out R7 turnaround
    issue(20'h12345, 0);
    issue(20'hAAAAA, 1);
    issue(20'h55555, 37);
    for (int i = 0; i < 20; i++)
      issue(AW'(i * 20'h0B3C7) ^ AW'(i << 13), i % 4);
    repeat (ACC + FLT + 6) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finish_run();
    end
  end
endmodule